// File: doc/BRIEF.md
# Fractional Clock Divider Field Encoder

This block turns a requested output divide ratio into the control fields that a programmable clock-output divider needs. The ratio arrives as an integer part and a fraction counted in eighths. From these the block derives a high count, a low count, an edge bit and a no-count bit. In fractional mode it also derives rise and fall waveform flags and a fractional phase. The fields are packed into three 16-bit words: a count word, a control word and a phase word. A configuration agent can then write those words into the divider.

Requests use a valid/ready handshake in which ready is always high. Every accepted request produces registered words one clock later, together with a one-cycle output valid pulse. Between requests the words keep their last value. The encoder does not search for divider settings and does not write to any hardware.

Top module: `frac_div_encoder`

## Requirements
- R1: While reset is held and after its release, out_valid is 0 and all three output words are 0 until the first request is accepted.
- R2: in_ready is 1 in every cycle after reset is released.
- R3: A request is accepted on a rising clock edge where in_valid and in_ready are both 1. out_valid is 1 in the cycle after an accepted request and 0 otherwise. When no request is accepted, all three words hold their value.
- R4: With in_frac = 0 (integer mode), high = in_div/2, edge = in_div mod 2 and low = in_div - high, kept modulo 64 so a count of 64 reads as 0. The frac field, frac-enable, the rise flag, the fall flag and the phase are all 0.
- R5: With in_frac != 0 (fractional mode), high = low = in_div/2, edge = in_div mod 2, the frac field equals in_frac and frac-enable is 1.
- R6: In fractional mode the rise flag is 1 exactly when edge is 0.
- R7: In fractional mode the fall flag is 1 when (edge == 0) XOR (in_frac == 1) is true, or when in_div == 2 and in_frac == 1; otherwise it is 0.
- R8: In fractional mode the 3-bit phase equals edge*4 + in_frac/2 (integer division).
- R9: The no-count bit is 1 exactly when in_div == 1 and in_frac == 0.
- R10: Each word has a fixed layout, and every bit not listed is 0.
  - Count word: high in bits [11:6], low in bits [5:0].
  - Control word: frac field in [14:12], frac-enable in [11], rise flag in [10], edge in [7], no-count in [6].
  - Phase word: phase in [13:11], fall flag in [10].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request ready (always 1 out of reset) |
| in_div | input | 7 | Integer part of the divide ratio |
| in_frac | input | 3 | Fractional part in eighths |
| out_valid | output | 1 | One-cycle pulse marking fresh words |
| out_word_cnt | output | 16 | Packed high and low counts |
| out_word_ctl | output | 16 | Packed frac, frac-enable, rise flag, edge and no-count |
| out_word_phase | output | 16 | Packed phase and fall flag |

## Verification
The assertions assume every accepted request is legal. The integer part must be at least 1 in integer mode and at least 2 in fractional mode. Only such requests give a meaningful divider setting, and the field relations checked at the output depend on that. The stimulus generator draws the integer part from those ranges, choosing the range by whether the drawn fraction is zero. The directed cases sit at the ends of the ranges: in_div of 1, 2 and 127, and fractions of 1 and 7.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

  localparam int DIV_W  = 7;
  localparam int FRAC_W = 3;
  localparam int CNT_W  = DIV_W - 1;
  localparam int PH_W   = FRAC_W;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic [CNT_W-1:0]  high;
    logic [CNT_W-1:0]  low;
    logic              edge_b;
    logic              nocount;
    logic              frac_en;
    logic [FRAC_W-1:0] frac;
    logic              wf_rise;
    logic              wf_fall;
    logic [PH_W-1:0]   phase;
  } fd_fields_t;

  // Arithmetic of the encoding, kept in functions for reuse.
  function automatic logic [CNT_W-1:0] fd_half(input logic [DIV_W-1:0] d);
    return d[DIV_W-1:1];
  endfunction

  function automatic logic [CNT_W-1:0] fd_ceil_half(input logic [DIV_W-1:0] d);
    return d[DIV_W-1:1] + CNT_W'(d[0]);
  endfunction

  function automatic logic fd_fall_flag(input logic [DIV_W-1:0] d,
                                        input logic [FRAC_W-1:0] f);
    logic even_d;
    logic one_f;
    even_d = ~d[0];
    one_f  = (f == FRAC_W'(1));
    return (even_d ^ one_f) | ((d == DIV_W'(2)) & one_f);
  endfunction

  function automatic logic [PH_W-1:0] fd_phase(input logic [DIV_W-1:0] d,
                                               input logic [FRAC_W-1:0] f);
    return {d[0], f[FRAC_W-1:1]};
  endfunction

endpackage

// File: rtl/fd_field_calc.sv
module fd_field_calc
  import frac_div_pkg::*;
(
  input  logic [DIV_W-1:0]  div_i,
  input  logic [FRAC_W-1:0] frac_i,
  output fd_fields_t        fields_o,
  output logic              frac_mode_o
);

  logic frac_mode;

  assign frac_mode   = (frac_i != '0);
  assign frac_mode_o = frac_mode;

  always_comb begin
    fields_o         = '0;
    fields_o.high    = fd_half(div_i);
    fields_o.edge_b  = div_i[0];
    fields_o.nocount = (div_i == DIV_W'(1)) & ~frac_mode;
    if (frac_mode) begin
      fields_o.low     = fd_half(div_i);
      fields_o.frac    = frac_i;
      fields_o.frac_en = 1'b1;
      fields_o.wf_rise = ~div_i[0];
      fields_o.wf_fall = fd_fall_flag(div_i, frac_i);
      fields_o.phase   = fd_phase(div_i, frac_i);
    end else begin
      fields_o.low = fd_ceil_half(div_i);
    end
  end

endmodule

// File: rtl/fd_word_pack.sv
module fd_word_pack
  import frac_div_pkg::*;
(
  input  fd_fields_t        fields_i,
  output logic [WORD_W-1:0] cnt_o,
  output logic [WORD_W-1:0] ctl_o,
  output logic [WORD_W-1:0] phase_o
);

  localparam int CNT_PAD = WORD_W - 2 * CNT_W;

  always_comb begin
    cnt_o = {{CNT_PAD{1'b0}}, fields_i.high, fields_i.low};

    ctl_o         = '0;
    ctl_o[14:12]  = fields_i.frac;
    ctl_o[11]     = fields_i.frac_en;
    ctl_o[10]     = fields_i.wf_rise;
    ctl_o[7]      = fields_i.edge_b;
    ctl_o[6]      = fields_i.nocount;

    phase_o        = '0;
    phase_o[13:11] = fields_i.phase;
    phase_o[10]    = fields_i.wf_fall;
  end

endmodule

// File: rtl/fd_out_reg.sv
module fd_out_reg
  import frac_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] cnt_i,
  input  logic [WORD_W-1:0] ctl_i,
  input  logic [WORD_W-1:0] phase_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] cnt_o,
  output logic [WORD_W-1:0] ctl_o,
  output logic [WORD_W-1:0] phase_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      cnt_o   <= '0;
      ctl_o   <= '0;
      phase_o <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) begin
        cnt_o   <= cnt_i;
        ctl_o   <= ctl_i;
        phase_o <= phase_i;
      end
    end
  end

endmodule

// File: rtl/frac_div_encoder.sv
module frac_div_encoder
  import frac_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DIV_W-1:0]  in_div,
  input  logic [FRAC_W-1:0] in_frac,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word_cnt,
  output logic [WORD_W-1:0] out_word_ctl,
  output logic [WORD_W-1:0] out_word_phase
);

  fd_fields_t        fields;
  logic              frac_mode;
  logic              accept;
  logic [WORD_W-1:0] nxt_cnt;
  logic [WORD_W-1:0] nxt_ctl;
  logic [WORD_W-1:0] nxt_phase;

  assign in_ready = rst_n;
  assign accept   = in_valid & in_ready;

  fd_field_calc u_calc (
    .div_i      (in_div),
    .frac_i     (in_frac),
    .fields_o   (fields),
    .frac_mode_o(frac_mode)
  );

  fd_word_pack u_pack (
    .fields_i(fields),
    .cnt_o   (nxt_cnt),
    .ctl_o   (nxt_ctl),
    .phase_o (nxt_phase)
  );

  fd_out_reg u_oreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .cnt_i  (nxt_cnt),
    .ctl_i  (nxt_ctl),
    .phase_i(nxt_phase),
    .valid_o(out_valid),
    .cnt_o  (out_word_cnt),
    .ctl_o  (out_word_ctl),
    .phase_o(out_word_phase)
  );

endmodule

// File: rtl/fd_encoder_chk.sv
module fd_encoder_chk
  import frac_div_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DIV_W-1:0]  in_div,
  input logic [FRAC_W-1:0] in_frac,
  input logic              frac_mode,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_word_cnt,
  input logic [WORD_W-1:0] out_word_ctl,
  input logic [WORD_W-1:0] out_word_phase
);

  logic acc;
  assign acc = in_valid & in_ready;

  p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

  p_valid_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_no_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !out_valid);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(out_word_cnt) && $stable(out_word_ctl) && $stable(out_word_phase)));

  p_int_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !frac_mode) |=> (out_word_ctl[14:10] == 5'd0 && out_word_phase == '0));

  p_frac_equal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_word_ctl[11]) |-> (out_word_cnt[11:6] == out_word_cnt[5:0]));

  p_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_word_ctl[11]) |-> (out_word_ctl[10] == !out_word_ctl[7]));

  p_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && frac_mode) |=> (out_word_phase[13] == $past(in_div[0]) &&
                            out_word_phase[12:11] == $past(in_frac[2:1])));

  p_nocount_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (out_word_ctl[6] == ($past(in_div) == DIV_W'(1) && $past(in_frac) == '0)));

  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word_cnt[15:12] == 4'd0 && out_word_ctl[15] == 1'b0 &&
                   out_word_ctl[9:8] == 2'd0 && out_word_ctl[5:0] == 6'd0 &&
                   out_word_phase[15:14] == 2'd0 && out_word_phase[9:0] == 10'd0));

endmodule

bind frac_div_encoder fd_encoder_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_div        (in_div),
  .in_frac       (in_frac),
  .frac_mode     (frac_mode),
  .out_valid     (out_valid),
  .out_word_cnt  (out_word_cnt),
  .out_word_ctl  (out_word_ctl),
  .out_word_phase(out_word_phase)
);

// File: tb/frac_div_encoder_test.sv
module frac_div_encoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [6:0]  in_div = '0;
  logic [2:0]  in_frac = '0;
  logic        out_valid;
  logic [15:0] out_word_cnt;
  logic [15:0] out_word_ctl;
  logic [15:0] out_word_phase;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  frac_div_encoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_div(in_div), .in_frac(in_frac), .out_valid(out_valid),
    .out_word_cnt(out_word_cnt), .out_word_ctl(out_word_ctl),
    .out_word_phase(out_word_phase)
  );

  function automatic logic [15:0] exp_cnt(int d, int f);
    int h, l;
    h = d / 2;
    l = (f == 0) ? (d - h) % 64 : h;
    return 16'((h << 6) + l);
  endfunction

  function automatic logic [15:0] exp_ctl(int d, int f);
    int e, w;
    e = d % 2;
    w = (e << 7);
    if (f == 0 && d == 1) w = w + 64;
    if (f != 0) begin
      w = w + (f << 12) + 2048;
      if (e == 0) w = w + 1024;
    end
    return 16'(w);
  endfunction

  function automatic logic [15:0] exp_phase(int d, int f);
    int e, ph, fall;
    if (f == 0) return 16'd0;
    e  = d % 2;
    ph = e * 4 + f / 2;
    if (f == 1) fall = (e == 1 || d == 2) ? 1 : 0;
    else        fall = (e == 0) ? 1 : 0;
    return 16'((ph << 11) + (fall << 10));
  endfunction

  task automatic check16(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(int d, int f);
    if (d == 1 && f == 0) return "R9";
    if (f == 1)           return "R7";
    if (f == 0)           return "R4";
    return "R5/R6/R8";
  endfunction

  task automatic send(int d, int f);
    @(negedge clk);
    in_valid = 1'b1;
    in_div   = 7'(d);
    in_frac  = 3'(f);
    @(negedge clk);
    in_valid = 1'b0;
    check16("R3", "out_valid after accept", {15'd0, out_valid}, 16'd1);
    check16(tag_of(d, f), "count word R10", out_word_cnt, exp_cnt(d, f));
    check16(tag_of(d, f), "control word R10", out_word_ctl, exp_ctl(d, f));
    check16(tag_of(d, f), "phase word R10", out_word_phase, exp_phase(d, f));
  endtask

  task automatic idle_check();
    logic [15:0] c0, c1, c2;
    c0 = out_word_cnt; c1 = out_word_ctl; c2 = out_word_phase;
    @(negedge clk);
    in_valid = 1'b0;
    in_div   = 7'($urandom_range(0, 127));
    in_frac  = 3'($urandom_range(0, 7));
    @(negedge clk);
    check16("R3", "out_valid idle", {15'd0, out_valid}, 16'd0);
    check16("R3", "count hold", out_word_cnt, c0);
    check16("R3", "control hold", out_word_ctl, c1);
    check16("R3", "phase hold", out_word_phase, c2);
    check16("R2", "in_ready", {15'd0, in_ready}, 16'd1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check16("R1", "out_valid in reset", {15'd0, out_valid}, 16'd0);
    check16("R1", "count in reset", out_word_cnt, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check16("R1", "out_valid after reset", {15'd0, out_valid}, 16'd0);
    check16("R1", "ctl after reset", out_word_ctl, 16'd0);
    check16("R1", "phase after reset", out_word_phase, 16'd0);
    check16("R2", "in_ready after reset", {15'd0, in_ready}, 16'd1);

    // Directed corners
    send(1, 0);    // R9 no-count
    send(2, 0);
    send(127, 0);  // R4 low of 64 wraps to 0
    send(2, 1);    // R7 special case
    send(3, 1);
    send(4, 1);
    send(5, 7);
    send(4, 7);
    send(2, 4);
    idle_check();
    // back-to-back requests
    @(negedge clk);
    in_valid = 1'b1; in_div = 7'd9; in_frac = 3'd3;
    @(negedge clk);
    in_div = 7'd10; in_frac = 3'd0;
    check16("R3", "b2b first ctl", out_word_ctl, exp_ctl(9, 3));
    @(negedge clk);
    in_valid = 1'b0;
    check16("R3", "b2b second cnt", out_word_cnt, exp_cnt(10, 0));
    check16("R3", "b2b second valid", {15'd0, out_valid}, 16'd1);

    for (int i = 0; i < 400; i++) begin
      int f, d;
      f = $urandom_range(0, 7);
      d = (f == 0) ? $urandom_range(1, 127) : $urandom_range(2, 127);
      send(d, f);
      if ($urandom_range(0, 3) == 0) idle_check();
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule